// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block sits beside one processor core and decides which interrupt the core takes next. Interrupt sources hand it a vector number together with a trigger mode. The block records each request in a pending array, one bit per vector, and notes the trigger mode in a matching trigger array. A higher vector number means a higher priority. When the highest pending vector outranks everything in service, the block raises its interrupt line to the core.

When the core acknowledges, the block moves the winning vector from pending to in service and returns its number. When the handler finishes, an end-of-interrupt strobe retires the highest in-service vector. The block also holds a task priority byte written by software. From that byte and the highest in-service class it computes a processor priority. Rejected requests set sticky error bits. A one-shot bypass flag, armed by an externally routed delivery, lets the next legal request land even if its pending bit is already set.

Top module: `lipc_top`

## Requirements
- R1: After reset, all pending, in-service and trigger bits are clear. The interrupt line is low, and the error status, task priority, processor priority, acknowledge vector and bypass flag are all zero.
- R2: A request whose vector is below 0x10 or above 0xFE is discarded and sets error bit 0 (illegal vector). Vectors 0x10 and 0xFE are both accepted.
- R3: A legal request whose pending bit is already set, with no bypass armed, is dropped. It sets error bit 1 (duplicate) and leaves the trigger bit unchanged.
- R4: An accepted request sets the vector's pending bit and writes its trigger bit from req_level (1 = level, 0 = edge). The change is visible on the probe outputs after the next rising edge.
- R5: A bypass_arm pulse lets the next legal request skip the duplicate check. That request raises no error and updates the trigger bit, and the flag then clears. An illegal request does not consume the flag.
- R6: int_line is high only when a vector is pending and the highest pending vector is numerically greater than the highest in-service vector. Otherwise it is low.
- R7: An acknowledge while int_line is high clears the highest pending bit and sets its in-service bit. ack_vector shows that vector after the edge, and int_line is re-evaluated from the new state. An acknowledge while int_line is low changes nothing.
- R8: An end-of-interrupt strobe clears the highest set in-service bit. With nothing in service it has no effect.
- R9: The processor priority equals the task priority byte when task priority bits [7:4] are greater than or equal to the in-service class. Otherwise it equals the in-service class shifted left by 4, with the low nibble zero. The in-service class is bits [7:4] of the highest in-service vector, or 0 when nothing is in service.
- R10: Error bits are sticky. err_clr clears them, but an error raised in the same cycle as err_clr stays set.
- R11: tpr_we loads tpr_wdata into the task priority byte, and the new value is seen on tpr after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_vector | input | 8 | Requested vector number |
| req_level | input | 1 | Trigger mode of the request, 1 = level |
| bypass_arm | input | 1 | Arms the one-shot duplicate-check bypass |
| ack | input | 1 | Core acknowledge |
| ack_vector | output | 8 | Vector handed over by the last taken acknowledge |
| int_line | output | 1 | Interrupt request to the core |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write enable |
| tpr_wdata | input | 8 | Task priority write data |
| tpr | output | 8 | Current task priority |
| ppr | output | 8 | Computed processor priority |
| err_clr | input | 1 | Clears the sticky error bits |
| err_status | output | 2 | Bit 0 illegal vector, bit 1 duplicate |
| probe_vector | input | 8 | Vector whose state bits are shown |
| probe_irr | output | 1 | Pending bit of probe_vector |
| probe_isr | output | 1 | In-service bit of probe_vector |
| probe_tmr | output | 1 | Trigger bit of probe_vector |

## Verification
Several properties are checked on every cycle:
- an illegal or duplicate request always leaves its error bit set one cycle later;
- a used bypass flag always clears;
- a taken acknowledge always moves its vector from pending to in service;
- an end-of-interrupt always clears the vector it retires;
- the processor priority never falls below the task priority.

Only the bench scenarios can show the others. These are the exact vector returned among many pending vectors, and the interrupt line staying low when an equal or higher vector is in service. They also include the trigger bit being kept across a rejected duplicate, and the error bits surviving err_clr when a new error comes in the same cycle.

// File: rtl/lipc_pkg.sv
package lipc_pkg;
   timeunit 1ns; timeprecision 100ps;
   localparam int ERR_W       = 2;
   localparam int ERR_ILLEGAL = 0;
   localparam int ERR_DUP     = 1;
   typedef logic [ERR_W-1:0] err_t;
endpackage

// File: rtl/lipc_prio_enc.sv
module lipc_prio_enc #(
   parameter int N  = 256,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  bits,
   output logic [IW-1:0] idx,
   output logic          valid
);
   timeunit 1ns; timeprecision 100ps;

   initial assert (N >= 2) else $error("lipc_prio_enc: N too small");

   always_comb begin
      idx   = '0;
      valid = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (bits[i]) begin
            idx   = IW'(i);
            valid = 1'b1;
         end
      end
   end
endmodule

// File: rtl/lipc_vec_bank.sv
module lipc_vec_bank #(
   parameter int NUM_VEC = 256,
   localparam int VW     = $clog2(NUM_VEC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [VW-1:0]      set_idx,
   input  logic               set_level,
   input  logic               ack_en,
   input  logic [VW-1:0]      ack_idx,
   input  logic               eoi_en,
   input  logic [VW-1:0]      eoi_idx,
   input  logic [VW-1:0]      probe_idx,
   output logic [NUM_VEC-1:0] irr,
   output logic [NUM_VEC-1:0] isr,
   output logic               probe_tmr
);
   timeunit 1ns; timeprecision 100ps;

   logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
   logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      localparam logic [VW-1:0] ID = VW'(v);
      logic hit_set, hit_ack, hit_eoi;
      assign hit_set  = set_en && (set_idx == ID);
      assign hit_ack  = ack_en && (ack_idx == ID);
      assign hit_eoi  = eoi_en && (eoi_idx == ID);
      assign irr_n[v] = hit_set | (irr_q[v] & ~hit_ack);
      assign isr_n[v] = hit_ack | (isr_q[v] & ~hit_eoi);
      assign tmr_n[v] = hit_set ? set_level : tmr_q[v];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q <= '0;
         isr_q <= '0;
         tmr_q <= '0;
      end else begin
         irr_q <= irr_n;
         isr_q <= isr_n;
         tmr_q <= tmr_n;
      end
   end

   assign irr       = irr_q;
   assign isr       = isr_q;
   assign probe_tmr = tmr_q[probe_idx];

   // R7: a taken acknowledge moves its vector from pending to in service
   assert_ack_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_en && !(set_en && set_idx == ack_idx)) |=>
         (isr_q[$past(ack_idx)] && !irr_q[$past(ack_idx)]));

   // R8: end of interrupt retires the selected in-service vector
   assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_en && !(ack_en && ack_idx == eoi_idx)) |=> !isr_q[$past(eoi_idx)]);
endmodule

// File: rtl/lipc_ppr_calc.sv
module lipc_ppr_calc #(
   parameter int VW = 8
) (
   input  logic [7:0]    tpr,
   input  logic          isr_valid,
   input  logic [VW-1:0] isr_idx,
   output logic [7:0]    ppr
);
   timeunit 1ns; timeprecision 100ps;

   initial assert (VW == 8) else $error("lipc_ppr_calc: vector width must be 8");

   logic [3:0] tpr_cls, isr_cls;
   assign tpr_cls = tpr[7:4];
   assign isr_cls = isr_valid ? isr_idx[VW-1 -: 4] : 4'h0;
   assign ppr     = (tpr_cls >= isr_cls) ? tpr : {isr_cls, 4'h0};
endmodule

// File: rtl/lipc_top.sv
module lipc_top #(
   parameter int NUM_VEC = 256,
   parameter int MIN_VEC = 16,
   parameter int MAX_VEC = 254,
   localparam int VW     = $clog2(NUM_VEC)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [VW-1:0]         req_vector,
   input  logic                  req_level,
   input  logic                  bypass_arm,
   input  logic                  ack,
   output logic [VW-1:0]         ack_vector,
   output logic                  int_line,
   input  logic                  eoi,
   input  logic                  tpr_we,
   input  logic [7:0]            tpr_wdata,
   output logic [7:0]            tpr,
   output logic [7:0]            ppr,
   input  logic                  err_clr,
   output logic [lipc_pkg::ERR_W-1:0] err_status,
   input  logic [VW-1:0]         probe_vector,
   output logic                  probe_irr,
   output logic                  probe_isr,
   output logic                  probe_tmr
);
   timeunit 1ns; timeprecision 100ps;
   import lipc_pkg::*;

   initial begin
      assert (NUM_VEC == (1 << VW)) else $error("lipc_top: NUM_VEC must be a power of two");
      assert (MIN_VEC <= MAX_VEC && MAX_VEC < NUM_VEC) else $error("lipc_top: bad vector range");
   end

   logic [NUM_VEC-1:0] irr, isr;
   logic [VW-1:0]      pend_idx, isr_idx;
   logic               pend_valid, isr_valid;
   logic [7:0]         tpr_q;
   err_t               err_q, err_set;
   logic               byp_q;
   logic [VW-1:0]      ack_q;

   lipc_prio_enc #(.N(NUM_VEC)) u_pend_enc (.bits(irr), .idx(pend_idx), .valid(pend_valid));
   lipc_prio_enc #(.N(NUM_VEC)) u_isr_enc  (.bits(isr), .idx(isr_idx),  .valid(isr_valid));

   // request screening
   logic legal, dup, accept, ack_fire, eoi_fire;
   assign legal    = (req_vector >= VW'(MIN_VEC)) && (req_vector <= VW'(MAX_VEC));
   assign dup      = irr[req_vector];
   assign accept   = req_valid && legal && (!dup || byp_q);
   assign err_set[ERR_ILLEGAL] = req_valid && !legal;
   assign err_set[ERR_DUP]     = req_valid && legal && dup && !byp_q;

   assign int_line = pend_valid && (!isr_valid || (pend_idx > isr_idx));
   assign ack_fire = ack && int_line;
   assign eoi_fire = eoi && isr_valid;

   lipc_vec_bank #(.NUM_VEC(NUM_VEC)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_en(accept), .set_idx(req_vector), .set_level(req_level),
      .ack_en(ack_fire), .ack_idx(pend_idx),
      .eoi_en(eoi_fire), .eoi_idx(isr_idx),
      .probe_idx(probe_vector),
      .irr(irr), .isr(isr), .probe_tmr(probe_tmr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tpr_q <= '0;
         err_q <= '0;
         byp_q <= 1'b0;
         ack_q <= '0;
      end else begin
         if (tpr_we)   tpr_q <= tpr_wdata;
         err_q <= (err_clr ? '0 : err_q) | err_set;
         byp_q <= bypass_arm | (byp_q & ~(req_valid && legal));
         if (ack_fire) ack_q <= pend_idx;
      end
   end

   lipc_ppr_calc #(.VW(VW)) u_ppr (
      .tpr(tpr_q), .isr_valid(isr_valid), .isr_idx(isr_idx), .ppr(ppr)
   );

   assign tpr        = tpr_q;
   assign err_status = err_q;
   assign ack_vector = ack_q;
   assign probe_irr  = irr[probe_vector];
   assign probe_isr  = isr[probe_vector];

   assert_illegal_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ((req_vector < VW'(MIN_VEC)) || (req_vector > VW'(MAX_VEC))))
         |=> err_status[ERR_ILLEGAL]);

   assert_dup_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && legal && irr[req_vector] && !byp_q) |=> err_status[ERR_DUP]);

   assert_bypass_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_q && req_valid && legal && !bypass_arm) |=> !byp_q);

   assert_ppr_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ppr >= tpr) && ((ppr == tpr) || (ppr[3:0] == 4'h0)));

   assert_line_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_valid) |-> !int_line);
endmodule

// File: tb/tb_lipc_top.sv
module tb_lipc_top;
   timeunit 1ns; timeprecision 100ps;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_level = 0, bypass_arm = 0, ack = 0, eoi = 0;
   logic tpr_we = 0, err_clr = 0;
   logic [7:0] req_vector = 0, tpr_wdata = 0, probe_vector = 0;
   logic [7:0] ack_vector, tpr, ppr;
   logic [1:0] err_status;
   logic int_line, probe_irr, probe_isr, probe_tmr;

   always #5 clk = ~clk;

   lipc_top dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
      .req_level(req_level), .bypass_arm(bypass_arm), .ack(ack), .ack_vector(ack_vector),
      .int_line(int_line), .eoi(eoi), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .tpr(tpr),
      .ppr(ppr), .err_clr(err_clr), .err_status(err_status), .probe_vector(probe_vector),
      .probe_irr(probe_irr), .probe_isr(probe_isr), .probe_tmr(probe_tmr)
   );

   int checks = 0, fails = 0;
   bit done = 0;

   // reference state
   logic [255:0] irr_m = '0, isr_m = '0, tmr_m = '0;
   logic [1:0]   err_m = '0;
   logic [7:0]   tpr_m = '0, ackv_m = '0;
   logic         byp_m = 1'b0;

   function automatic int hi(input logic [255:0] b);
      int r = -1;
      for (int i = 0; i < 256; i++) if (b[i]) r = i;
      return r;
   endfunction

   function automatic logic line_of(input logic [255:0] p, input logic [255:0] s);
      int hp = hi(p);
      int hs = hi(s);
      return (hp >= 0) && (hp > hs);
   endfunction

   function automatic logic [7:0] ppr_of(input logic [7:0] t, input logic [255:0] s);
      int hs = hi(s);
      logic [3:0] ic = (hs < 0) ? 4'h0 : 4'(hs >> 4);
      return (t[7:4] >= ic) ? t : {ic, 4'h0};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic rv, input logic [7:0] vv, input logic lv, input logic arm,
                       input logic ak, input logic eo, input logic tw, input logic [7:0] td,
                       input logic ec, input logic [7:0] pv);
      logic [255:0] irr_n, isr_n, tmr_n;
      logic [1:0] err_n;
      logic byp_n, legal;
      logic [7:0] ackv_n, tpr_n;
      int hp, hs;
      @(negedge clk);
      req_valid = rv; req_vector = vv; req_level = lv; bypass_arm = arm; ack = ak;
      eoi = eo; tpr_we = tw; tpr_wdata = td; err_clr = ec; probe_vector = pv;
      hp = hi(irr_m); hs = hi(isr_m);
      irr_n = irr_m; isr_n = isr_m; tmr_n = tmr_m; ackv_n = ackv_m;
      err_n = ec ? 2'b00 : err_m;
      byp_n = byp_m;
      tpr_n = tw ? td : tpr_m;
      legal = (vv >= 8'h10) && (vv <= 8'hFE);
      if (ak && line_of(irr_m, isr_m)) begin
         irr_n[hp] = 1'b0; isr_n[hp] = 1'b1; ackv_n = 8'(hp);
      end
      if (eo && hs >= 0) isr_n[hs] = 1'b0;
      if (rv) begin
         if (!legal) err_n[0] = 1'b1;
         else begin
            if (irr_m[vv] && !byp_m) err_n[1] = 1'b1;
            else begin irr_n[vv] = 1'b1; tmr_n[vv] = lv; end
            byp_n = 1'b0;
         end
      end
      if (arm) byp_n = 1'b1;
      @(posedge clk); #1;
      irr_m = irr_n; isr_m = isr_n; tmr_m = tmr_n; err_m = err_n;
      byp_m = byp_n; tpr_m = tpr_n; ackv_m = ackv_n;
      chk("R6 int_line", int'(int_line), int'(line_of(irr_m, isr_m)));
      chk("R9 ppr", int'(ppr), int'(ppr_of(tpr_m, isr_m)));
      chk("R2 R3 R10 err_status", int'(err_status), int'(err_m));
      chk("R11 tpr", int'(tpr), int'(tpr_m));
      chk("R7 ack_vector", int'(ack_vector), int'(ackv_m));
      chk("R4 R5 probe_irr", int'(probe_irr), int'(irr_m[pv]));
      chk("R7 R8 probe_isr", int'(probe_isr), int'(isr_m[pv]));
      chk("R3 R4 probe_tmr", int'(probe_tmr), int'(tmr_m[pv]));
   endtask

   // request only
   task automatic rq(input logic [7:0] v, input logic lv);
      step(1, v, lv, 0, 0, 0, 0, 8'h00, 0, v);
   endtask

   function automatic logic [7:0] pick_vec();
      case ($urandom % 10)
         0: return ($urandom % 2) ? 8'hFF : 8'($urandom % 16);
         1: return 8'h10;
         2: return 8'hFE;
         3: return 8'h20;
         4: return 8'h21;
         5: return 8'h80;
         6: return 8'h8F;
         default: return 8'h10 + 8'($urandom % 239);
      endcase
   endfunction

   initial begin
      #(2_000_000);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 int_line", int'(int_line), 0);
      chk("R1 err_status", int'(err_status), 0);
      chk("R1 ppr", int'(ppr), 0);
      chk("R1 tpr", int'(tpr), 0);
      chk("R1 ack_vector", int'(ack_vector), 0);
      chk("R1 probe_irr", int'(probe_irr), 0);

      rq(8'h20, 0);                                   // R4 accepted edge
      rq(8'h20, 1);                                   // R3 duplicate, tmr stays 0
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h20);         // R10 clear
      rq(8'h05, 0);                                   // R2 below range
      rq(8'hFF, 0);                                   // R2 above range
      rq(8'h10, 1);                                   // R2 lower edge legal
      rq(8'hFE, 0);                                   // R2 upper edge legal
      step(1, 8'h0F, 0, 0, 0, 0, 0, 0, 1, 8'h20);     // R10 clear with new error kept
      step(0, 0, 0, 0, 1, 0, 0, 0, 0, 8'hFE);         // R7 ack takes 0xFE
      chk("R7 ack_vector directed", int'(ack_vector), 8'hFE);
      step(0, 0, 0, 0, 1, 0, 0, 0, 0, 8'h20);         // R7 ack ignored, line low
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 8'hFE);         // R8 retire 0xFE
      step(0, 0, 0, 1, 0, 0, 0, 0, 1, 8'h20);         // R5 arm bypass
      rq(8'h02, 0);                                   // R5 illegal keeps flag
      rq(8'h20, 1);                                   // R5 bypass: no error, tmr=1
      chk("R5 no dup error", int'(err_status[1]), 0);
      chk("R5 tmr updated", int'(probe_tmr), 1);
      rq(8'h20, 0);                                   // R5 flag used up -> dup
      chk("R5 flag consumed", int'(err_status[1]), 1);
      step(0, 0, 0, 0, 0, 0, 1, 8'h35, 0, 8'h20);     // R11 R9 tpr write
      step(0, 0, 0, 0, 1, 0, 0, 0, 0, 8'h20);         // ack 0x20
      step(0, 0, 0, 0, 1, 0, 0, 0, 0, 8'h10);         // line low: 0x10 below 0x20
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 8'h20);
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 8'h10);         // R8 with empty isr after
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 8'h10);

      for (int n = 0; n < 4000; n++) begin
         logic [7:0] v = pick_vec();
         step(($urandom % 2) == 0, v, 1'($urandom), ($urandom % 20) == 0,
              ($urandom % 10) < 3, ($urandom % 10) < 2, ($urandom % 20) == 0,
              8'($urandom), ($urandom % 20) == 0,
              (($urandom % 2) == 0) ? v : 8'(hi(isr_m) < 0 ? 16 : hi(isr_m)));
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule